// File: doc/BRIEF.md
# Command/Response FIFO Controller

This block runs the per-locality transfer of a command into a processing backend and the return of its response. The host writes the command one byte at a time through a FIFO port. The header of the command carries its own total length. The block uses that length to decide when it has received enough bytes, then it launches the backend on a go request. When the backend finishes, the host drains the response through the same FIFO port. The host can also rewind the response and read it again, or throw the transfer away.

A status word reports the handshake flags, a constant family code and a dynamic burst count. The host steers the block by writing action bits to that word. Locality arbitration and interrupt registers sit outside the block. The block gives them one-cycle event pulses: command ready, status valid, data available and abort done. The backend reads the stored command through its own byte port, fills the response buffer through a write port, and reports completion with a done pulse that carries the response length.

Top module: `cmd_fifo_ctrl`

## Requirements
- R1: After reset the block is idle and the status word holds no flags. Family sits at bits 27:26 (value of FAMILY, default 1). The burst count at bits 23:8 equals DEPTH. Status flag positions are: valid bit 7, command-ready bit 6, data-available bit 4, expect bit 3, selftest-done bit 2. Go (bit 5) and retry (bit 1) always read as 0.
- R2: A status write acts only when exactly one of the action bits is set: bit 6 (command ready), bit 5 (go) or bit 1 (retry). A write with any other combination is ignored. In idle, command ready moves the block to ready, leaves command-ready as the only flag, and pulses ev_cmd_ready.
- R3: FIFO writes change nothing while idle, executing or holding a response.
- R4: The first FIFO write in ready stores the byte and enters reception with expect and valid set. The burst count then shows the free command buffer space.
- R5: Once more than 5 bytes are held, expect stays set while the header length exceeds the byte count and clears when they match. The length is a 32-bit big-endian value at byte offsets 2 to 5.
- R6: A FIFO write to a full buffer drops the byte and clears expect.
- R7: Go is accepted only in reception with expect clear. It pulses be_start with be_cmd_len equal to the bytes stored, and the backend can read the stored bytes by address.
- R8: be_done during execution sets valid and data-available, pulses ev_data_avail and ev_sts_valid, and makes the burst count equal the response length.
- R9: FIFO reads return response bytes in order while data is available. After the last byte only valid remains and ev_sts_valid pulses. Every other FIFO read returns 0xFF.
- R10: When host_byte is set, a status read caps the burst count at 0xFF.
- R11: Retry while holding a response rewinds the read position and restores valid plus data-available.
- R12: Command ready during reception or execution aborts in one cycle. The offsets clear, the block returns to ready with command-ready set, and ev_abort_done pulses. During execution be_cancel also pulses, and a later be_done is ignored.
- R13: Command ready while holding a response clears data-available and returns to ready with command-ready set.
- R14: Selftest-done is set by be_done with be_selftest high and survives every later status update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (pops the FIFO when host_fifo is set) |
| host_fifo | input | 1 | 1 selects the FIFO, 0 selects the status word |
| host_byte | input | 1 | Single-byte status read (caps the burst count) |
| host_wdata | input | 8 | Write data: FIFO byte or status action bits |
| host_rdata | output | 32 | Read data: status word or FIFO byte |
| be_start | output | 1 | Pulse: command handed to the backend |
| be_cancel | output | 1 | Pulse: running command aborted |
| be_cmd_len | output | $clog2(DEPTH)+1 | Bytes stored in the command buffer |
| be_cmd_addr | input | $clog2(DEPTH) | Backend command read address |
| be_cmd_data | output | 8 | Command byte at be_cmd_addr |
| be_rsp_we | input | 1 | Backend response write enable |
| be_rsp_addr | input | $clog2(DEPTH) | Backend response write address |
| be_rsp_data | input | 8 | Backend response byte |
| be_done | input | 1 | Pulse: backend finished |
| be_rsp_len | input | $clog2(DEPTH)+1 | Response length qualified by be_done |
| be_selftest | input | 1 | Self test completed, qualified by be_done |
| ev_cmd_ready | output | 1 | Event: command-ready raised |
| ev_sts_valid | output | 1 | Event: status valid |
| ev_data_avail | output | 1 | Event: response available |
| ev_abort_done | output | 1 | Event: abort finished |

## Verification
Most internal faults show up in the burst count field. A wrong write or read offset shifts the count in the status word on the very next read. It can also deliver the response bytes out of order on the next FIFO pop. A wrong state shows as an accepted write that should have been ignored, a missing be_start or a stray event pulse, all within one cycle of the offending access. A bad length compare leaves expect set one write too long or clears it early, and the go request then succeeds or is refused against expectation.

// File: rtl/cfc_pkg.sv
package cfc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READY,
    ST_RX,
    ST_EXEC,
    ST_COMPL
  } cfc_state_e;

  localparam int unsigned BIT_VALID    = 7;
  localparam int unsigned BIT_CMDRDY   = 6;
  localparam int unsigned BIT_DAVAIL   = 4;
  localparam int unsigned BIT_EXPECT   = 3;
  localparam int unsigned BIT_SELFTEST = 2;
  localparam int unsigned BURST_LSB    = 8;
  localparam int unsigned BURST_W      = 16;
  localparam int unsigned FAMILY_LSB   = 26;
  localparam int unsigned HDR_LEN_OFS  = 2;
  localparam int unsigned HDR_LEN_BYTES = 4;

endpackage

// File: rtl/cfc_byte_ram.sv
module cfc_byte_ram #(
  parameter int unsigned DEPTH = 512,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];

endmodule

// File: rtl/cfc_len_capture.sv
module cfc_len_capture import cfc_pkg::*; #(
  parameter int unsigned OW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [OW-1:0] offset,
  input  logic [7:0]    byte_in,
  output logic [31:0]   len_now
);

  logic [7:0] len_b_q [HDR_LEN_BYTES];

  for (genvar g = 0; g < HDR_LEN_BYTES; g++) begin : g_lane
    localparam logic [OW-1:0] LANE_OFS = OW'(HDR_LEN_OFS + g);
    logic hit;
    assign hit = (offset == LANE_OFS);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        len_b_q[g] <= '0;
      end else if (we && hit) begin
        len_b_q[g] <= byte_in;
      end
    end

    // most significant byte first; the byte being written now is merged in
    assign len_now[8*(HDR_LEN_BYTES-1-g) +: 8] = hit ? byte_in : len_b_q[g];
  end

endmodule

// File: rtl/cfc_burst.sv
module cfc_burst import cfc_pkg::*; #(
  parameter int unsigned DEPTH = 512,
  localparam int unsigned OW = $clog2(DEPTH) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               davail,
  input  logic [OW-1:0]      rsp_len,
  input  logic [OW-1:0]      rd_off,
  input  logic [OW-1:0]      wr_off,
  input  logic               byte_rd,
  output logic [BURST_W-1:0] burst
);

  localparam logic [OW-1:0] DEPTH_W = OW'(DEPTH);

  logic [OW-1:0]      raw;
  logic [BURST_W-1:0] raw_ext;

  always_comb begin
    raw     = davail ? (rsp_len - rd_off) : (DEPTH_W - wr_off);
    raw_ext = BURST_W'(raw);
    if (byte_rd && (raw_ext > BURST_W'(8'hFF))) begin
      burst = BURST_W'(8'hFF);
    end else begin
      burst = raw_ext;
    end
  end

  AST_BURST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    burst <= BURST_W'(DEPTH)) else $error("burst above depth"); // R10
  AST_BYTE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    byte_rd |-> (burst <= BURST_W'(8'hFF))) else $error("byte read not capped"); // R10

endmodule

// File: rtl/cmd_fifo_ctrl.sv
module cmd_fifo_ctrl import cfc_pkg::*; #(
  parameter int unsigned DEPTH  = 512,
  parameter logic [1:0]  FAMILY = 2'b01,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned OW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic          host_fifo,
  input  logic          host_byte,
  input  logic [7:0]    host_wdata,
  output logic [31:0]   host_rdata,
  output logic          be_start,
  output logic          be_cancel,
  output logic [OW-1:0] be_cmd_len,
  input  logic [AW-1:0] be_cmd_addr,
  output logic [7:0]    be_cmd_data,
  input  logic          be_rsp_we,
  input  logic [AW-1:0] be_rsp_addr,
  input  logic [7:0]    be_rsp_data,
  input  logic          be_done,
  input  logic [OW-1:0] be_rsp_len,
  input  logic          be_selftest,
  output logic          ev_cmd_ready,
  output logic          ev_sts_valid,
  output logic          ev_data_avail,
  output logic          ev_abort_done
);

  localparam logic [OW-1:0] DEPTH_W = OW'(DEPTH);
  localparam logic [OW-1:0] HDR_MIN = OW'(5);

  cfc_state_e    state_q, state_d;
  logic [OW-1:0] wr_off_q, wr_off_d;
  logic [OW-1:0] rd_off_q, rd_off_d;
  logic [OW-1:0] rsp_len_q, rsp_len_d;
  logic          valid_q, valid_d;
  logic          cr_q, cr_d;
  logic          da_q, da_d;
  logic          ex_q, ex_d;
  logic          st_q, st_d;

  logic          cmd_we;
  logic [31:0]   hdr_len;
  logic [7:0]    rsp_byte;
  logic [BURST_W-1:0] burst;

  logic          fifo_wr, fifo_rd, sts_wr;
  logic [2:0]    act;
  logic          op_cr, op_go, op_rt;

  assign fifo_wr = host_wr && host_fifo;
  assign fifo_rd = host_rd && host_fifo;
  assign sts_wr  = host_wr && !host_fifo;
  assign act     = {host_wdata[6], host_wdata[5], host_wdata[1]};
  assign op_cr   = sts_wr && (act == 3'b100);
  assign op_go   = sts_wr && (act == 3'b010);
  assign op_rt   = sts_wr && (act == 3'b001);

  // ---------------------------------------------------------------- storage
  cfc_byte_ram #(.DEPTH(DEPTH)) i_cmd_ram (
    .clk   (clk),
    .we    (cmd_we),
    .waddr (wr_off_q[AW-1:0]),
    .wdata (host_wdata),
    .raddr (be_cmd_addr),
    .rdata (be_cmd_data)
  );

  cfc_byte_ram #(.DEPTH(DEPTH)) i_rsp_ram (
    .clk   (clk),
    .we    (be_rsp_we),
    .waddr (be_rsp_addr),
    .wdata (be_rsp_data),
    .raddr (rd_off_q[AW-1:0]),
    .rdata (rsp_byte)
  );

  cfc_len_capture #(.OW(OW)) i_len (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cmd_we),
    .offset  (wr_off_q),
    .byte_in (host_wdata),
    .len_now (hdr_len)
  );

  cfc_burst #(.DEPTH(DEPTH)) i_burst (
    .clk     (clk),
    .rst_n   (rst_n),
    .davail  (da_q),
    .rsp_len (rsp_len_q),
    .rd_off  (rd_off_q),
    .wr_off  (wr_off_q),
    .byte_rd (host_byte),
    .burst   (burst)
  );

  // ---------------------------------------------------------------- next state
  always_comb begin
    logic store_c;
    logic abort_c;
    store_c       = 1'b0;
    abort_c       = 1'b0;
    state_d       = state_q;
    wr_off_d      = wr_off_q;
    rd_off_d      = rd_off_q;
    rsp_len_d     = rsp_len_q;
    valid_d       = valid_q;
    cr_d          = cr_q;
    da_d          = da_q;
    ex_d          = ex_q;
    st_d          = st_q;
    cmd_we        = 1'b0;
    be_start      = 1'b0;
    be_cancel     = 1'b0;
    ev_cmd_ready  = 1'b0;
    ev_sts_valid  = 1'b0;
    ev_data_avail = 1'b0;
    ev_abort_done = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (op_cr) begin
          state_d = ST_READY;
          {valid_d, cr_d, da_d, ex_d} = 4'b0100;
          ev_cmd_ready = 1'b1;
        end
      end
      ST_READY: begin
        if (op_cr) begin
          wr_off_d = '0;
          rd_off_d = '0;
        end else if (fifo_wr) begin
          state_d = ST_RX;
          store_c = 1'b1;
        end
      end
      ST_RX: begin
        if (op_cr) begin
          abort_c = 1'b1;
        end else if (fifo_wr && ex_q) begin
          store_c = 1'b1;
        end else if (op_go && !ex_q) begin
          be_start = 1'b1;
          state_d  = ST_EXEC;
        end
      end
      ST_EXEC: begin
        if (op_cr) begin
          abort_c   = 1'b1;
          be_cancel = 1'b1;
        end else if (be_done) begin
          state_d   = ST_COMPL;
          wr_off_d  = '0;
          rd_off_d  = '0;
          {valid_d, cr_d, da_d, ex_d} = 4'b1010;
          rsp_len_d = (be_rsp_len > DEPTH_W) ? DEPTH_W : be_rsp_len;
          st_d      = st_q || be_selftest;
          ev_data_avail = 1'b1;
          ev_sts_valid  = 1'b1;
        end
      end
      ST_COMPL: begin
        if (op_cr) begin
          state_d  = ST_READY;
          wr_off_d = '0;
          rd_off_d = '0;
          {valid_d, cr_d, da_d, ex_d} = 4'b0100;
          ev_cmd_ready = 1'b1;
        end else if (op_rt) begin
          rd_off_d = '0;
          {valid_d, cr_d, da_d, ex_d} = 4'b1010;
        end else if (fifo_rd && da_q) begin
          rd_off_d = rd_off_q + 1'b1;
          if (rd_off_d >= rsp_len_q) begin
            {valid_d, cr_d, da_d, ex_d} = 4'b1000;
            ev_sts_valid = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase

    if (store_c) begin
      if (wr_off_q < DEPTH_W) begin
        cmd_we   = 1'b1;
        wr_off_d = wr_off_q + 1'b1;
        {valid_d, cr_d, da_d, ex_d} = 4'b1001;
        if (wr_off_d > HDR_MIN) begin
          ex_d = (hdr_len > 32'(wr_off_d));
          if (!valid_q) begin
            ev_sts_valid = 1'b1;
          end
        end
      end else begin
        {valid_d, cr_d, da_d, ex_d} = 4'b1000;
      end
    end

    if (abort_c) begin
      state_d  = ST_READY;
      wr_off_d = '0;
      rd_off_d = '0;
      {valid_d, cr_d, da_d, ex_d} = 4'b0100;
      ev_cmd_ready  = 1'b1;
      ev_abort_done = 1'b1;
    end
  end

  // ---------------------------------------------------------------- registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      wr_off_q  <= '0;
      rd_off_q  <= '0;
      rsp_len_q <= '0;
      valid_q   <= 1'b0;
      cr_q      <= 1'b0;
      da_q      <= 1'b0;
      ex_q      <= 1'b0;
      st_q      <= 1'b0;
    end else begin
      state_q   <= state_d;
      wr_off_q  <= wr_off_d;
      rd_off_q  <= rd_off_d;
      rsp_len_q <= rsp_len_d;
      valid_q   <= valid_d;
      cr_q      <= cr_d;
      da_q      <= da_d;
      ex_q      <= ex_d;
      st_q      <= st_d;
    end
  end

  // ---------------------------------------------------------------- read path
  logic [31:0] sts_word;

  always_comb begin
    sts_word = '0;
    sts_word[FAMILY_LSB +: 2]      = FAMILY;
    sts_word[BURST_LSB +: BURST_W] = burst;
    sts_word[BIT_VALID]    = valid_q;
    sts_word[BIT_CMDRDY]   = cr_q;
    sts_word[BIT_DAVAIL]   = da_q;
    sts_word[BIT_EXPECT]   = ex_q;
    sts_word[BIT_SELFTEST] = st_q;
  end

  assign host_rdata = host_fifo
                    ? {24'h0, ((state_q == ST_COMPL) && da_q) ? rsp_byte : 8'hFF}
                    : sts_word;
  assign be_cmd_len = wr_off_q;

  // ---------------------------------------------------------------- assertions
  AST_GO_ENTERS_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    be_start |=> (state_q == ST_EXEC)) else $error("go did not enter execution"); // R7
  AST_EXPECT_ONLY_RX: assert property (@(posedge clk) disable iff (!rst_n)
    ex_q |-> (state_q == ST_RX)) else $error("expect outside reception"); // R5
  AST_DONE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_data_avail |=> (da_q && (rd_off_q == '0) && (state_q == ST_COMPL)))
    else $error("completion not entered"); // R8
  AST_IDLE_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_IDLE) && fifo_wr) |=> ((state_q == ST_IDLE) && $stable(wr_off_q)))
    else $error("idle write took effect"); // R3
  AST_ABORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort_done |=> ((state_q == ST_READY) && cr_q && (wr_off_q == '0)))
    else $error("abort did not settle"); // R12
  AST_SELFTEST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    st_q |=> st_q) else $error("selftest flag lost"); // R14
  AST_OFFSET_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_off_q <= DEPTH_W) && (rd_off_q <= DEPTH_W)) else $error("offset overflow"); // R6

endmodule

// File: tb/test_cmd_fifo_ctrl.sv
module test_cmd_fifo_ctrl;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned DEPTH = 512;
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned OW = AW + 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          host_wr, host_rd, host_fifo, host_byte;
  logic [7:0]    host_wdata;
  logic [31:0]   host_rdata;
  logic          be_start, be_cancel;
  logic [OW-1:0] be_cmd_len;
  logic [AW-1:0] be_cmd_addr;
  logic [7:0]    be_cmd_data;
  logic          be_rsp_we;
  logic [AW-1:0] be_rsp_addr;
  logic [7:0]    be_rsp_data;
  logic          be_done;
  logic [OW-1:0] be_rsp_len;
  logic          be_selftest;
  logic          ev_cmd_ready, ev_sts_valid, ev_data_avail, ev_abort_done;

  int n_chk = 0;
  int n_bad = 0;

  // pulses and data captured during the last operation
  logic        p_cr, p_sv, p_da, p_ab, p_start, p_cancel;
  logic [31:0] p_rdata;

  cmd_fifo_ctrl #(.DEPTH(DEPTH), .FAMILY(2'b01)) i_cmd_fifo_ctrl (
    .clk(clk), .rst_n(rst_n),
    .host_wr(host_wr), .host_rd(host_rd), .host_fifo(host_fifo), .host_byte(host_byte),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .be_start(be_start), .be_cancel(be_cancel), .be_cmd_len(be_cmd_len),
    .be_cmd_addr(be_cmd_addr), .be_cmd_data(be_cmd_data),
    .be_rsp_we(be_rsp_we), .be_rsp_addr(be_rsp_addr), .be_rsp_data(be_rsp_data),
    .be_done(be_done), .be_rsp_len(be_rsp_len), .be_selftest(be_selftest),
    .ev_cmd_ready(ev_cmd_ready), .ev_sts_valid(ev_sts_valid),
    .ev_data_avail(ev_data_avail), .ev_abort_done(ev_abort_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] sw(bit v, bit c, bit d, bit e, bit s, int b);
    return (32'd1 << 26) | (32'(b) << 8) | (32'(v) << 7) | (32'(c) << 6)
         | (32'(d) << 4) | (32'(e) << 3) | (32'(s) << 2);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    host_wr = 0; host_rd = 0; host_fifo = 0; host_byte = 0; host_wdata = '0;
    be_rsp_we = 0; be_done = 0; be_selftest = 0;
  endtask

  task automatic sample();
    #1;
    p_cr = ev_cmd_ready; p_sv = ev_sts_valid; p_da = ev_data_avail;
    p_ab = ev_abort_done; p_start = be_start; p_cancel = be_cancel;
    p_rdata = host_rdata;
    @(posedge clk);
    #1 idle_inputs();
  endtask

  task automatic wr_sts(logic [7:0] v);
    @(negedge clk); host_wr = 1; host_fifo = 0; host_wdata = v; sample();
  endtask

  task automatic wr_byte(logic [7:0] b);
    @(negedge clk); host_wr = 1; host_fifo = 1; host_wdata = b; sample();
  endtask

  task automatic rd_fifo();
    @(negedge clk); host_rd = 1; host_fifo = 1; sample();
  endtask

  task automatic rd_sts(bit byte_mode);
    @(negedge clk); host_fifo = 0; host_byte = byte_mode; sample();
  endtask

  task automatic send_bytes(int n, int hdrlen);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      if (i == 0) b = 8'h80;
      else if (i == 1) b = 8'h01;
      else if (i < 6) b = 8'(hdrlen >> (8 * (5 - i)));
      else b = 8'(i);
      wr_byte(b);
    end
  endtask

  task automatic fill_rsp(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      be_rsp_we = 1; be_rsp_addr = AW'(i); be_rsp_data = 8'hD0 + 8'(i);
      @(posedge clk); #1 be_rsp_we = 0;
    end
  endtask

  task automatic finish_be(int len, bit st);
    @(negedge clk); be_done = 1; be_rsp_len = OW'(len); be_selftest = st; sample();
  endtask

  // ------------------------------------------------------------ scenarios
  task automatic t_reset();
    rd_sts(0); check("R1 reset status", p_rdata, sw(0,0,0,0,0,512));
    rd_sts(1); check("R10 byte-read cap", p_rdata, sw(0,0,0,0,0,255));
  endtask

  task automatic t_idle();
    wr_byte(8'h55); rd_sts(0); check("R3 idle write ignored", p_rdata, sw(0,0,0,0,0,512));
    wr_sts(8'h60); rd_sts(0); check("R2 multi-bit write ignored", p_rdata, sw(0,0,0,0,0,512));
    wr_sts(8'h40); check("R2 cmd-ready event", 32'(p_cr), 1);
    rd_sts(0); check("R2 ready status", p_rdata, sw(0,1,0,0,0,512));
  endtask

  task automatic t_receive();
    send_bytes(3, 10);
    rd_sts(0); check("R4 reception flags", p_rdata, sw(1,0,0,1,0,509));
    wr_sts(8'h20); check("R7 go refused with expect", 32'(p_start), 0);
    for (int i = 3; i < 6; i++) wr_byte(i == 5 ? 8'h0A : 8'h00);
    rd_sts(0); check("R5 expect held at 6 bytes", p_rdata, sw(1,0,0,1,0,506));
    for (int i = 6; i < 10; i++) wr_byte(8'(i));
    rd_sts(0); check("R5 expect cleared at length", p_rdata, sw(1,0,0,0,0,502));
  endtask

  task automatic t_go();
    wr_sts(8'h20);
    check("R7 be_start", 32'(p_start), 1);
    check("R7 be_cmd_len", 32'(be_cmd_len), 10);
    be_cmd_addr = AW'(5); #1;
    check("R7 backend read", 32'(be_cmd_data), 32'h0A);
    wr_byte(8'hEE); rd_sts(0); check("R3 exec write ignored", p_rdata, sw(1,0,0,0,0,502));
  endtask

  task automatic t_done();
    fill_rsp(6);
    finish_be(6, 0);
    check("R8 data-avail event", 32'(p_da), 1);
    check("R8 sts-valid event", 32'(p_sv), 1);
    rd_sts(0); check("R8 completion status", p_rdata, sw(1,0,1,0,0,6));
  endtask

  task automatic t_read();
    rd_fifo(); check("R9 byte 0", p_rdata, 32'hD0);
    rd_fifo(); check("R9 byte 1", p_rdata, 32'hD1);
    wr_byte(8'h77); rd_sts(0); check("R3 completion write ignored", p_rdata, sw(1,0,1,0,0,4));
    wr_sts(8'h02); rd_sts(0); check("R11 retry rewinds", p_rdata, sw(1,0,1,0,0,6));
    for (int i = 0; i < 6; i++) begin
      rd_fifo(); check("R11 reread byte", p_rdata, 32'hD0 + 32'(i));
    end
    check("R9 last byte event", 32'(p_sv), 1);
    rd_sts(0); check("R9 drained status", p_rdata, sw(1,0,0,0,0,512));
    rd_fifo(); check("R9 empty read", p_rdata, 32'hFF);
    wr_sts(8'h40); check("R13 cmd-ready event", 32'(p_cr), 1);
    rd_sts(0); check("R13 back to ready", p_rdata, sw(0,1,0,0,0,512));
  endtask

  task automatic t_abort_rx();
    send_bytes(3, 10);
    wr_sts(8'h40);
    check("R12 abort-done rx", 32'(p_ab), 1);
    rd_sts(0); check("R12 status after rx abort", p_rdata, sw(0,1,0,0,0,512));
  endtask

  task automatic t_abort_exec();
    send_bytes(10, 10); wr_sts(8'h20);
    wr_sts(8'h40);
    check("R12 cancel pulse", 32'(p_cancel), 1);
    check("R12 abort-done exec", 32'(p_ab), 1);
    finish_be(6, 0); check("R12 late done ignored", 32'(p_da), 0);
    rd_sts(0); check("R12 status after exec abort", p_rdata, sw(0,1,0,0,0,512));
  endtask

  task automatic t_selftest();
    send_bytes(10, 10); wr_sts(8'h20);
    finish_be(6, 1);
    rd_sts(0); check("R14 selftest set", p_rdata, sw(1,0,1,0,1,6));
    wr_sts(8'h40); rd_sts(0); check("R13 shortcut clears data-avail", p_rdata, sw(0,1,0,0,1,512));
  endtask

  task automatic t_full();
    send_bytes(DEPTH, 32'h1000);
    rd_sts(0); check("R6 full, expect held", p_rdata, sw(1,0,0,1,1,0));
    wr_byte(8'h99); rd_sts(0); check("R6 overflow clears expect", p_rdata, sw(1,0,0,0,1,0));
    wr_sts(8'h20); check("R6 go after overflow", 32'(p_start), 1);
    check("R6 stored length", 32'(be_cmd_len), DEPTH);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle_inputs();
    be_cmd_addr = '0; be_rsp_addr = '0; be_rsp_data = '0; be_rsp_len = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_idle();
    t_receive();
    t_go();
    t_done();
    t_read();
    t_abort_rx();
    t_abort_exec();
    t_selftest();
    t_full();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule